// File: doc/BRIEF.md
# Key-Unlocked Indexed Configuration Space

This block holds a small configuration register space reached through two byte-wide ports that share one write strobe: an index port and a data port. The space starts locked. Software opens it by writing a key byte to the index port twice in a row, and closes it by writing an exit byte to the index port. While the space is open, software writes a register number to the index port and then reads or writes that register through the data port.

One global register holds a logical-device number. It picks which of several identical per-device banks the bank register numbers reach. Each bank holds an enable bit, a 16-bit base address written as a high and a low byte, and an 8-bit interrupt-line select. The current bank contents drive the block's outputs, so the decoders that sit next to this block can use them. Fixed chip and vendor identifiers can be read as high and low bytes. Reads have no side effects and are combinational.

Top module: `cfg_idx_port`

## Requirements
- R1: After reset the space is locked, the logical-device number is 0, and every bank output (enable, base, interrupt select) is 0.
- R2: Two back-to-back index-port writes of KEY (default 0x87) open the space. After a single KEY write the space is still locked.
- R3: An index-port write of any value other than KEY, placed between the two KEY writes, restarts the sequence. The space stays locked until two new adjacent KEY writes arrive.
- R4: An index-port write of EXIT (default 0xAA) while open locks the space. While locked, every read on either port returns 0xFF.
- R5: Data-port writes while locked have no effect on any register or output.
- R6: While open, an index-port write stores the register number, and an index-port read returns it. Data-port accesses reach the register that number selects.
- R7: Register 0x07 holds the logical-device number and reads back in full. Bank registers reach only bank N, where N is that number. When N is NUM_DEV or larger, bank register reads return 0x00 and bank register writes are dropped.
- R8: The bank registers are: 0x30 enable (bit 0 stored, other bits read 0), 0x60 base high byte, 0x61 base low byte, and 0x70 interrupt select (8 bits). Their values appear on dev_en_o, dev_base_o and dev_irq_o, in slices indexed by device.
- R9: Registers 0x20/0x21 read CHIP_ID high and low, and 0x23/0x24 read VENDOR_ID high and low. Writes to them have no effect.
- R10: Every other register number reads 0x00 and ignores writes. A read-modify-write of a full-byte register changes only the bits that were modified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Write strobe for the selected port |
| sel_data_i | input | 1 | 0 selects the index port, 1 selects the data port |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Combinational read byte for the selected port |
| cfg_open_o | output | 1 | High while the space is unlocked |
| dev_en_o | output | NUM_DEV | Enable bit of each bank |
| dev_base_o | output | 16*NUM_DEV | Base address of each bank |
| dev_irq_o | output | 8*NUM_DEV | Interrupt select of each bank |

## Verification
The bench tries every non-key byte as an interruption between two key writes. A design that kept a half-finished unlock across the interruption would open early, and every check in that sweep would read a value other than 0xFF. It writes every register number under every logical-device number, including one past the last bank, and reads them all back against a model of the bank contents. This exposes a bank written through the wrong device number, an out-of-range number that aliases onto a real bank, an identifier that can be overwritten, and an unmapped register that keeps a value. Locked writes are followed by an unlock and a readback, so a lock that only masks reads and still lets writes through is caught.

// File: rtl/cfg_idx_pkg.sv
package cfg_idx_pkg;
  typedef enum logic [1:0] {LK_SHUT, LK_HALF, LK_OPEN} lock_e;
  localparam logic [7:0] REG_LDN      = 8'h07;
  localparam logic [7:0] REG_CHIP_HI  = 8'h20;
  localparam logic [7:0] REG_CHIP_LO  = 8'h21;
  localparam logic [7:0] REG_VEND_HI  = 8'h23;
  localparam logic [7:0] REG_VEND_LO  = 8'h24;
  localparam logic [7:0] REG_DEV_EN   = 8'h30;
  localparam logic [7:0] REG_BASE_HI  = 8'h60;
  localparam logic [7:0] REG_BASE_LO  = 8'h61;
  localparam logic [7:0] REG_IRQ_SEL  = 8'h70;
endpackage

// File: rtl/cfg_unlock.sv
module cfg_unlock
  import cfg_idx_pkg::*;
#(
  parameter logic [7:0] KEY  = 8'h87,
  parameter logic [7:0] EXIT = 8'hAA
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idx_wr_i,
  input  logic [7:0] wdata_i,
  output logic       open_o
);
  lock_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (idx_wr_i) begin
      unique case (st_q)
        LK_SHUT: st_d = (wdata_i == KEY) ? LK_HALF : LK_SHUT;
        LK_HALF: st_d = (wdata_i == KEY) ? LK_OPEN : LK_SHUT;
        LK_OPEN: st_d = (wdata_i == EXIT) ? LK_SHUT : LK_OPEN;
        default: st_d = LK_SHUT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= LK_SHUT;
    else         st_q <= st_d;

  assign open_o = (st_q == LK_OPEN);
endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
  import cfg_idx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic [7:0]  wdata_i,
  output logic        en_o,
  output logic [15:0] base_o,
  output logic [7:0]  irq_o,
  output logic [7:0]  rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      base_o <= '0;
      irq_o  <= '0;
    end else if (we_i) begin
      case (addr_i)
        REG_DEV_EN:  en_o         <= wdata_i[0];
        REG_BASE_HI: base_o[15:8] <= wdata_i;
        REG_BASE_LO: base_o[7:0]  <= wdata_i;
        REG_IRQ_SEL: irq_o        <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      REG_DEV_EN:  rdata_o = {7'b0, en_o};
      REG_BASE_HI: rdata_o = base_o[15:8];
      REG_BASE_LO: rdata_o = base_o[7:0];
      REG_IRQ_SEL: rdata_o = irq_o;
      default:     rdata_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/cfg_idx_port.sv
module cfg_idx_port
  import cfg_idx_pkg::*;
#(
  parameter int          NUM_DEV   = 4,
  parameter logic [7:0]  KEY       = 8'h87,
  parameter logic [7:0]  EXIT      = 8'hAA,
  parameter logic [15:0] CHIP_ID   = 16'h0408,
  parameter logic [15:0] VENDOR_ID = 16'h1934
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_i,
  input  logic                   sel_data_i,
  input  logic [7:0]             wdata_i,
  output logic [7:0]             rdata_o,
  output logic                   cfg_open_o,
  output logic [NUM_DEV-1:0]     dev_en_o,
  output logic [16*NUM_DEV-1:0]  dev_base_o,
  output logic [8*NUM_DEV-1:0]   dev_irq_o
);
  localparam int SEL_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

  logic [7:0] idx_q, ldn_q;
  logic       idx_wr, data_wr, ldn_ok;
  logic [7:0] bank_rd [NUM_DEV];

  assign idx_wr  = wr_i & ~sel_data_i;
  assign data_wr = wr_i & sel_data_i & cfg_open_o;
  assign ldn_ok  = (ldn_q < 8'(NUM_DEV));

  cfg_unlock #(.KEY(KEY), .EXIT(EXIT)) u_unlock (
    .clk_i(clk_i), .rst_ni(rst_ni), .idx_wr_i(idx_wr),
    .wdata_i(wdata_i), .open_o(cfg_open_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      ldn_q <= '0;
    end else begin
      if (idx_wr && cfg_open_o && wdata_i != EXIT) idx_q <= wdata_i;
      if (data_wr && idx_q == REG_LDN)             ldn_q <= wdata_i;
    end
  end

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_bank
    logic we;
    assign we = data_wr & ldn_ok & (ldn_q[SEL_W-1:0] == SEL_W'(g));
    cfg_dev_bank u_bank (
      .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we), .addr_i(idx_q),
      .wdata_i(wdata_i), .en_o(dev_en_o[g]),
      .base_o(dev_base_o[16*g +: 16]), .irq_o(dev_irq_o[8*g +: 8]),
      .rdata_o(bank_rd[g])
    );
  end

  always_comb begin
    if (!cfg_open_o)      rdata_o = 8'hFF;
    else if (!sel_data_i) rdata_o = idx_q;
    else begin
      case (idx_q)
        REG_LDN:     rdata_o = ldn_q;
        REG_CHIP_HI: rdata_o = CHIP_ID[15:8];
        REG_CHIP_LO: rdata_o = CHIP_ID[7:0];
        REG_VEND_HI: rdata_o = VENDOR_ID[15:8];
        REG_VEND_LO: rdata_o = VENDOR_ID[7:0];
        default:     rdata_o = ldn_ok ? bank_rd[ldn_q[SEL_W-1:0]] : 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/cfg_idx_port_chk.sv
module cfg_idx_port_chk #(
  parameter int         NUM_DEV = 4,
  parameter logic [7:0] KEY     = 8'h87,
  parameter logic [7:0] EXIT    = 8'hAA
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  wr_i,
  input logic                  sel_data_i,
  input logic [7:0]            wdata_i,
  input logic [7:0]            rdata_o,
  input logic                  cfg_open_o,
  input logic [NUM_DEV-1:0]    dev_en_o,
  input logic [16*NUM_DEV-1:0] dev_base_o,
  input logic [8*NUM_DEV-1:0]  dev_irq_o
);
  always @(posedge clk_i)
    if (!rst_ni) begin
      assert_reset_state_R1: assert (!cfg_open_o && dev_en_o == '0 &&
                                     dev_base_o == '0 && dev_irq_o == '0);
    end

  assert_open_needs_key_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_open_o) |-> $past(wr_i && !sel_data_i && wdata_i == KEY));

  assert_exit_locks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_open_o && wr_i && !sel_data_i && wdata_i == EXIT) |=> !cfg_open_o);

  assert_locked_reads_ff_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_open_o |-> rdata_o == 8'hFF);

  assert_locked_no_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_open_o |=> ($stable(dev_en_o) && $stable(dev_base_o) && $stable(dev_irq_o)));
endmodule

bind cfg_idx_port cfg_idx_port_chk #(.NUM_DEV(NUM_DEV), .KEY(KEY), .EXIT(EXIT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .sel_data_i(sel_data_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .cfg_open_o(cfg_open_o),
  .dev_en_o(dev_en_o), .dev_base_o(dev_base_o), .dev_irq_o(dev_irq_o)
);

// File: tb/tb_cfg_idx_port.sv
module tb_cfg_idx_port;
  localparam int          CLK_PERIOD = 10;
  localparam int          NDEV = 4;
  localparam logic [7:0]  KEY  = 8'h87;
  localparam logic [7:0]  EXIT = 8'hAA;
  localparam logic [15:0] CHIP = 16'h0408;
  localparam logic [15:0] VEND = 16'h1934;

  logic clk_i = 0, rst_ni = 0, wr_i = 0, sel_data_i = 0;
  logic [7:0] wdata_i = 0, rdata_o;
  logic cfg_open_o;
  logic [NDEV-1:0] dev_en_o;
  logic [16*NDEV-1:0] dev_base_o;
  logic [8*NDEV-1:0] dev_irq_o;

  int checks = 0, errors = 0;
  logic        m_en   [NDEV];
  logic [15:0] m_base [NDEV];
  logic [7:0]  m_irq  [NDEV];
  logic [7:0]  m_ldn;

  cfg_idx_port #(.NUM_DEV(NDEV), .KEY(KEY), .EXIT(EXIT), .CHIP_ID(CHIP), .VENDOR_ID(VEND)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .sel_data_i(sel_data_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .cfg_open_o(cfg_open_o),
    .dev_en_o(dev_en_o), .dev_base_o(dev_base_o), .dev_irq_o(dev_irq_o));

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic port, input logic [7:0] d);
    @(negedge clk_i);
    sel_data_i = port; wdata_i = d; wr_i = 1;
    @(posedge clk_i); #1 wr_i = 0;
  endtask

  task automatic rd(input logic port, output logic [7:0] d);
    @(negedge clk_i);
    sel_data_i = port; wr_i = 0;
    #1 d = rdata_o;
  endtask

  task automatic unlock(); wr(0, KEY); wr(0, KEY); endtask

  function automatic logic [7:0] exp_reg(input logic [7:0] idx);
    logic ok = m_ldn < NDEV;
    int n = ok ? int'(m_ldn) : 0;
    case (idx)
      8'h07: return m_ldn;
      8'h20: return CHIP[15:8];
      8'h21: return CHIP[7:0];
      8'h23: return VEND[15:8];
      8'h24: return VEND[7:0];
      8'h30: return ok ? {7'b0, m_en[n]} : 8'h00;
      8'h60: return ok ? m_base[n][15:8] : 8'h00;
      8'h61: return ok ? m_base[n][7:0] : 8'h00;
      8'h70: return ok ? m_irq[n] : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_wr(input logic [7:0] idx, input logic [7:0] d);
    if (idx == 8'h07) m_ldn = d;
    else if (m_ldn < NDEV) begin
      case (idx)
        8'h30: m_en[m_ldn]         = d[0];
        8'h60: m_base[m_ldn][15:8] = d;
        8'h61: m_base[m_ldn][7:0]  = d;
        8'h70: m_irq[m_ldn]        = d;
        default: ;
      endcase
    end
  endtask

  task automatic chk_outputs(input string req);
    for (int k = 0; k < NDEV; k++) begin
      chk(req, dev_en_o[k], m_en[k]);
      chk(req, dev_base_o[16*k +: 16], m_base[k]);
      chk(req, dev_irq_o[8*k +: 8], m_irq[k]);
    end
  endtask

  initial begin
    #(CLK_PERIOD*50000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    for (int k = 0; k < NDEV; k++) begin m_en[k] = 0; m_base[k] = 0; m_irq[k] = 0; end
    m_ldn = 0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;

    // R1 reset state
    chk("R1 open", cfg_open_o, 0);
    chk_outputs("R1 outputs");
    rd(0, r); chk("R1 idx read locked", r, 8'hFF);

    // R2 single key does not open
    wr(0, KEY);
    rd(0, r); chk("R2 single key idx", r, 8'hFF);
    rd(1, r); chk("R2 single key data", r, 8'hFF);
    wr(0, KEY);
    chk("R2 double key opens", cfg_open_o, 1);
    wr(0, 8'h07); rd(0, r); chk("R6 index readback", r, 8'h07);
    rd(1, r); chk("R7 ldn reset 0", r, 8'h00);
    wr(0, EXIT);
    chk("R4 exit locks", cfg_open_o, 0);
    rd(1, r); chk("R4 locked data read", r, 8'hFF);

    // R3 every non-key interruption restarts the sequence
    for (int b = 0; b < 256; b++) begin
      if (8'(b) == KEY) continue;
      wr(0, KEY); wr(0, 8'(b)); wr(0, KEY);
      rd(0, r); chk("R3 interrupted", r, 8'hFF);
      wr(0, KEY);
      chk("R3 fresh pair opens", cfg_open_o, 1);
      wr(0, EXIT);
    end

    // R5 locked data writes dropped
    wr(0, 8'h30); wr(1, 8'h01); wr(0, 8'h70); wr(1, 8'h5A); wr(1, 8'h07);
    chk_outputs("R5 locked write outputs");
    unlock();
    wr(0, 8'h70); rd(1, r); chk("R5 locked write irq", r, 8'h00);
    wr(0, 8'h07); rd(1, r); chk("R5 locked write ldn", r, 8'h00);

    // R7 R8 R9 R10 write sweep: every register under every ldn incl. out of range
    for (int n = 0; n <= NDEV; n++) begin
      wr(0, 8'h07); wr(1, 8'(n)); model_wr(8'h07, 8'(n));
      for (int i = 0; i < 256; i++) begin
        logic [7:0] d;
        if (i == 8'h07 || 8'(i) == EXIT) continue;
        d = 8'((i * 7) ^ (n * 53) ^ 8'h3C);
        wr(0, 8'(i)); wr(1, d); model_wr(8'(i), d);
      end
      chk_outputs("R8 bank outputs");
    end
    for (int n = NDEV; n >= 0; n--) begin
      wr(0, 8'h07); wr(1, 8'(n)); model_wr(8'h07, 8'(n));
      for (int i = 0; i < 256; i++) begin
        if (8'(i) == EXIT) continue;
        wr(0, 8'(i)); rd(1, r);
        chk("R7 R9 R10 readback", r, exp_reg(8'(i)));
      end
    end

    // R10 read-modify-write sets one bit only
    wr(0, 8'h07); wr(1, 8'h02); model_wr(8'h07, 8'h02);
    wr(0, 8'h70); rd(1, r);
    wr(1, r | 8'h10); model_wr(8'h70, r | 8'h10);
    rd(1, r); chk("R10 rmw", r, m_irq[2]);
    chk_outputs("R10 rmw outputs");

    // R4 after exit all reads FF, R5 outputs hold
    wr(0, EXIT);
    rd(0, r); chk("R4 final idx", r, 8'hFF);
    rd(1, r); chk("R4 final data", r, 8'hFF);
    wr(1, 8'h00);
    chk_outputs("R5 final hold");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule